// File: doc/BRIEF.md
# Periodic Tick Timer

This block is a down-counting timer with a configurable width (24 bits by default), reached over a simple single-beat 32-bit register bus. Software writes a reload value and turns the timer on. The counter then steps down on every core clock or on every pulse of an external reference tick-enable, depending on a source-select bit. On the tick that finds the counter at zero, the timer does three things. It sets a sticky count flag. It can pulse an interrupt request. It reloads from the reload register, so each period lasts reload + 1 ticks.

Every bus request is answered one cycle later with a response valid, read data and an error bit. A request without the privilege attribute receives an error and leaves all state untouched. Reading the status register hands back the count flag and clears it. Writing the current-value register with any data restarts the period. A reload value of zero makes the timer switch itself off when it expires.

Top module: `sys_tick_timer`

## Requirements
- R1: After reset, the status, reload and current-value registers all read zero.
- R2: Register offsets: status 0x0, reload 0x4, current value 0x8, calibration 0xC. Status bit 0 is run enable, bit 1 is interrupt enable, bit 2 is source select and bit 16 is the count flag. A status write changes only bits 2:0.
- R3: The reload register keeps 24 bits. Its bits 31:24 read zero and ignore writes.
- R4: While enabled, the counter steps down by one on each selected tick. A tick that finds it at zero is an expiry, so one period spans reload + 1 ticks. Reading the current value returns the count as it was before the access edge.
- R5: Source select 1 counts every core clock. Source select 0 counts only cycles in which the reference tick input is high.
- R6: On expiry the counter reloads and the count flag sets. If interrupt enable is 1, the irq output is high for exactly the cycle after the expiry. If it is 0, irq stays low.
- R7: A read of the status register returns the flag and clears it. If an expiry occurs in the same cycle as that read, the read returns the old flag and the flag ends set.
- R8: If the reload value is zero at expiry, hardware clears run enable and counting stops. The flag is still set.
- R9: Any write to the current-value register clears the count flag and ignores its data. While enabled, the counter reloads from the reload register. While disabled, the counter is zeroed, so the next enable starts from the reload value.
- R10: Clearing run enable freezes the counter, and the current value then reads zero. Setting run enable again resumes from the frozen count if it is non-zero, and loads the reload value otherwise.
- R11: Changing the source-select bit while the timer stays enabled reloads the counter at once.
- R12: The calibration register reads the constant 10000. Other offsets read zero, and writes to them have no effect.
- R13: A request with the privilege input low gets a response with the error bit set and data zero, and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | Synchronous one-cycle reference tick-enable |
| bus_valid | input | 1 | Request present this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte offset of the word register |
| bus_wdata | input | 32 | Write data |
| bus_priv | input | 1 | Privileged access attribute |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Error response (unprivileged access) |
| rsp_rdata | output | 32 | Read data, zero for writes and errors |
| irq | output | 1 | One-cycle interrupt request pulse |

## Verification
Two things can land on the same clock edge: an expiry, which sets the count flag, and a status read, which clears it. The bench loads a reload value of 3 in core-clock mode and counts the edges from the enabling write. It then places a status read exactly on the expiry edge. That read must return the flag still clear, the read on the next cycle must return it set, and the read after that must return it clear again. The irq pulse on the same edge is sampled in the cycle that follows it.

// File: rtl/sys_tick_timer.sv
module sys_tick_timer #(
  parameter int CNT_W     = 24,
  parameter int ADDR_W    = 8,
  parameter int CAL_VALUE = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_priv,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_CUR    = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_CAL    = ADDR_W'(12);
  localparam int FLAG_BIT = 16;

  logic             en, tickint, src, flag;
  logic [CNT_W-1:0] reload, cur, cur_nx;
  logic [31:0]      rd_data;

  logic acc, wr_ctrl, rd_ctrl, wr_rel, wr_cur;
  logic tick, expire, en_rise, en_fall, src_flip;
  logic unused_wdata;

  assign acc     = bus_valid & bus_priv;
  assign wr_ctrl = acc &  bus_write & (bus_addr == A_CTRL);
  assign rd_ctrl = acc & ~bus_write & (bus_addr == A_CTRL);
  assign wr_rel  = acc &  bus_write & (bus_addr == A_RELOAD);
  assign wr_cur  = acc &  bus_write & (bus_addr == A_CUR);
  assign unused_wdata = ^bus_wdata;

  assign tick     = en & (src | ref_tick);
  assign expire   = tick & (cur == '0);
  assign en_rise  = wr_ctrl &  bus_wdata[0] & ~en;
  assign en_fall  = wr_ctrl & ~bus_wdata[0] &  en;
  assign src_flip = wr_ctrl &  bus_wdata[0] &  en & (bus_wdata[2] != src);

  always_comb begin
    if (wr_cur)        cur_nx = en ? reload : '0;
    else if (en_rise)  cur_nx = (cur == '0) ? reload : cur;
    else if (en_fall)  cur_nx = cur;
    else if (src_flip) cur_nx = reload;
    else if (expire)   cur_nx = reload;
    else if (tick)     cur_nx = cur - 1'b1;
    else               cur_nx = cur;
  end

  always_comb begin
    rd_data = '0;
    case (bus_addr)
      A_CTRL: begin
        rd_data[FLAG_BIT] = flag;
        rd_data[2:0]      = {src, tickint, en};
      end
      A_RELOAD: rd_data = 32'(reload);
      A_CUR:    rd_data = en ? 32'(cur) : '0;
      A_CAL:    rd_data = 32'(CAL_VALUE);
      default:  rd_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b0;
      tickint <= 1'b0;
      src     <= 1'b0;
      flag    <= 1'b0;
      reload  <= '0;
      cur     <= '0;
      irq     <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en      <= bus_wdata[0];
        tickint <= bus_wdata[1];
        src     <= bus_wdata[2];
      end else if (expire && reload == '0) begin
        en <= 1'b0;
      end
      if (wr_rel) reload <= bus_wdata[CNT_W-1:0];
      cur  <= cur_nx;
      flag <= expire | (flag & ~(rd_ctrl | wr_cur));
      irq  <= expire & tickint;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= bus_valid;
      rsp_err   <= bus_valid & ~bus_priv;
      rsp_rdata <= (acc & ~bus_write) ? rd_data : '0;
    end
  end

  AST_UNPRIV_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_priv |=> rsp_valid && rsp_err && rsp_rdata == '0); // R13
  AST_UNPRIV_NO_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_priv |=> $stable(reload) && $stable({tickint, src})); // R13
  AST_EXPIRE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag); // R7
  AST_ZERO_RELOAD_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    expire && reload == '0 && !wr_ctrl |=> !en); // R8
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(tickint)); // R6
  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !wr_cur && !wr_ctrl |=> $stable(cur)); // R10
  AST_CAL_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !bus_write && bus_addr == A_CAL |=> rsp_rdata == 32'(CAL_VALUE)); // R12
endmodule

// File: tb/sys_tick_timer_tb.sv
module sys_tick_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0, bus_priv = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rsp_valid, rsp_err, irq;
  logic [31:0] rsp_rdata;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [32:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  sys_tick_timer u_dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_priv(bus_priv),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  task automatic op(input logic wr, input logic [7:0] a, input logic [31:0] d,
                    input logic p, input logic [31:0] ed, input logic ee, input string tag);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d; bus_priv = p;
    exp_q.push_back({ee, ed});
    tag_q.push_back(tag);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    op(1'b1, a, d, 1'b1, 32'h0, 1'b0, tag);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] ed, input string tag);
    op(1'b0, a, 32'h0, 1'b1, ed, 1'b0, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    checks++;
    if (irq !== e) begin
      failures++;
      $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, e);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      logic [32:0] e;
      string t;
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R13 unexpected response actual=%h expected=none", rsp_rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({rsp_err, rsp_rdata} !== e) begin
          failures++;
          $display("FAIL %s actual=err%0b/%h expected=err%0b/%h", t, rsp_err, rsp_rdata, e[32], e[31:0]);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R4 watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(8'h0, 32'h0, "R1 status");
    rd(8'h4, 32'h0, "R1 reload");
    rd(8'h8, 32'h0, "R1 current");
    // R3 reload width
    wr(8'h4, 32'hFFFF_FFFF, "R3 write");
    rd(8'h4, 32'h00FF_FFFF, "R3 upper bits");
    // R2 only bits 2:0 writable
    wr(8'h0, 32'hFFFF_FFF8, "R2 write");
    rd(8'h0, 32'h0, "R2 status fields");
    // R12 calibration and undefined offsets
    rd(8'hC, 32'd10000, "R12 calibration");
    rd(8'h10, 32'h0, "R12 undefined read");
    wr(8'h14, 32'hAB, "R12 undefined write");
    rd(8'h4, 32'h00FF_FFFF, "R12 undefined write ignored");
    // R13 unprivileged
    op(1'b1, 8'h4, 32'h5, 1'b0, 32'h0, 1'b1, "R13 unpriv write");
    rd(8'h4, 32'h00FF_FFFF, "R13 reload unchanged");
    op(1'b0, 8'hC, 32'h0, 1'b0, 32'h0, 1'b1, "R13 unpriv read");
    // R4 / R10 / R9 / R11 / R5, core clock
    wr(8'h4, 32'd100, "R4 reload");
    wr(8'h0, 32'h5, "R4 enable");
    rd(8'h8, 32'd100, "R4 first count");
    rd(8'h8, 32'd99, "R4 step");
    wr(8'h0, 32'h4, "R10 disable");
    rd(8'h8, 32'd0, "R10 reads zero when off");
    rd(8'h0, 32'h4, "R10 status off");
    wr(8'h0, 32'h5, "R10 re-enable");
    rd(8'h8, 32'd98, "R10 resume frozen");
    rd(8'h8, 32'd97, "R10 continue");
    wr(8'h8, 32'h123, "R9 write current");
    rd(8'h8, 32'd100, "R9 reloaded");
    rd(8'h4, 32'd100, "R9 data ignored");
    wr(8'h0, 32'h1, "R11 source flip");
    rd(8'h8, 32'd100, "R11 reloaded");
    rd(8'h8, 32'd100, "R5 holds without ref tick");
    ref_tick = 1'b1;
    idle(1);
    ref_tick = 1'b0;
    rd(8'h8, 32'd99, "R5 ref tick step");
    // R7 / R6 same-cycle expiry and status read
    wr(8'h0, 32'h0, "R7 stop");
    wr(8'h4, 32'd3, "R7 reload");
    wr(8'h8, 32'h0, "R9 zero when off");
    rd(8'h0, 32'h0, "R7 flag clear");
    wr(8'h0, 32'h7, "R7 enable");
    idle(3);
    rd(8'h0, 32'h7, "R7 read on expiry edge");
    chk_irq(1'b1, "R6 pulse");
    rd(8'h0, 32'h0001_0007, "R7 set wins");
    chk_irq(1'b0, "R6 single cycle");
    rd(8'h0, 32'h7, "R7 cleared by read");
    rd(8'h8, 32'd1, "R4 count");
    rd(8'h8, 32'd0, "R4 zero phase");
    chk_irq(1'b1, "R6 second pulse");
    rd(8'h8, 32'd3, "R6 reloaded");
    wr(8'h8, 32'hFFFF, "R9 clear flag");
    rd(8'h0, 32'h7, "R9 flag cleared");
    // R8 zero reload, R6 no irq when disabled
    wr(8'h0, 32'h4, "R8 stop");
    wr(8'h4, 32'h0, "R8 reload zero");
    wr(8'h8, 32'h0, "R8 clear count");
    wr(8'h0, 32'h5, "R8 enable");
    idle(1);
    chk_irq(1'b0, "R6 no pulse when int off");
    rd(8'h0, 32'h0001_0004, "R8 self disabled");
    rd(8'h8, 32'h0, "R8 current zero");
    idle(4);
    rd(8'h0, 32'h4, "R8 stays stopped");
    idle(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule